// File: doc/BRIEF.md
# UART Status Flag Controller

This block keeps the five status flags of a UART and updates them from two sources. One source is single-cycle event strobes from the transmit and receive datapaths. The other is a small register bus. The transmit strobes report that the holding register has moved into the shifter and that a data frame has finished. The receive strobes report that a received word is ready for the receive data register and that the line has gone idle.

The register bus has separate read and write strobes for the status register and the data register. Three flags clear through a two-step sequence: first a status read arms the clear, then the next data register access completes it. The block also drives the load enable of the receive data register. It holds that enable low when the register still holds unread data, so the buffered word is kept and the incoming word is dropped. One combined interrupt output comes from the flags and their enable inputs.

Every input here is a control strobe or a level, and no data stream passes through the block, so there is no valid/ready handshake. The flag registers take new values on the clock edge after an event. The load enable and the interrupt are combinational.

Top module: `uart_flag_ctrl`

## Requirements
- R1: Status layout: bit 7 is transmit-empty, bit 6 is transmission-complete, bit 5 is receive-not-empty, bit 4 is idle, bit 3 is overrun, and bits 2..0 always read 0. After reset, bits 7 and 6 are 1 and every other bit is 0.
- R2: A transmit-shift event sets transmit-empty on the next edge. Any data register write clears it.
- R3: A frame-done event sets transmission-complete. It is cleared by an armed data register write, or by a status write with bit 6 equal to 0. A status write with bit 6 equal to 1 leaves it unchanged.
- R4: Receive-not-empty is set when a received word is loaded. It is cleared by any data register read, or by a status write with bit 5 equal to 0.
- R5: The load enable is high in the same cycle as a receive-ready event if, and only if, receive-not-empty is 0.
- R6: An idle event sets idle. Idle is cleared by an armed data register read. Once idle has been set, further idle events have no effect until a received word has been loaded.
- R7: A receive-ready event while receive-not-empty is 1 sets overrun and does not load the word. Overrun is cleared by an armed data register read.
- R8: A status read arms the two-step clear of transmission-complete, idle and overrun. The next data register access consumes the arm, whether it is a read or a write. A set event for a flag during or after the arming read disarms that flag only.
- R9: When a set event and a clear fall in the same cycle, the flag ends set.
- R10: The interrupt is high when any of these holds: transmit-empty and its enable, transmission-complete and its enable, idle and its enable, or receive-not-empty or overrun together with the receive enable.
- R11: Status writes never change transmit-empty, idle or overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_tx_shift | input | 1 | Holding register moved into transmit shifter |
| ev_tx_done | input | 1 | Data frame transmission finished |
| ev_rx_ready | input | 1 | Received word ready for the receive data register |
| ev_idle | input | 1 | Idle line detected |
| en_txe | input | 1 | Interrupt enable for transmit-empty |
| en_tc | input | 1 | Interrupt enable for transmission-complete |
| en_rx | input | 1 | Interrupt enable for receive-not-empty and overrun |
| en_idle | input | 1 | Interrupt enable for idle |
| sr_rd | input | 1 | Status register read strobe |
| sr_wr | input | 1 | Status register write strobe |
| sr_wdata | input | STAT_W | Status register write data |
| dr_rd | input | 1 | Data register read strobe |
| dr_wr | input | 1 | Data register write strobe |
| status | output | STAT_W | Status word |
| rdr_load | output | 1 | Receive data register load enable |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with the default 8-bit status word, which is the only width the fixed bit layout supports. At that width every flag, each of the three per-flag arms and the idle lock can be reached within a few cycles of random strobes. This puts same-cycle set/clear collisions, status reads that coincide with set events, and long gaps between arming and the data access within reach of a short run.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int STAT_W_DEF = 8;
  // bit positions of the status word (software decodes these)
  localparam int B_TXE  = 7;
  localparam int B_TC   = 6;
  localparam int B_RXNE = 5;
  localparam int B_IDLE = 4;
  localparam int B_OVR  = 3;
  // flags cleared by the two-step sequence
  localparam int NSEQ    = 3;
  localparam int SQ_TC   = 0;
  localparam int SQ_IDLE = 1;
  localparam int SQ_OVR  = 2;
  // interrupt sources
  localparam int NIRQ = 4;
endpackage

// File: rtl/uart_flag_seqclr.sv
module uart_flag_seqclr (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,     // status read
  input  logic set_i,     // set event of the guarded flag
  input  logic access_i,  // any data register access
  input  logic sel_i,     // the access type that clears this flag
  output logic clr_o
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n)        armed <= 1'b0;
    else if (set_i)    armed <= 1'b0;
    else if (arm_i)    armed <= 1'b1;
    else if (access_i) armed <= 1'b0;
  end

  assign clr_o = armed & sel_i;

  AST_SET_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> !clr_o) else $error("set event left flag armed"); // R8
endmodule

// File: rtl/uart_flag_irq.sv
module uart_flag_irq #(
  parameter int N = 4
) (
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic [N-1:0] hit;
  for (genvar g = 0; g < N; g++) begin : g_src
    assign hit[g] = src_i[g] & en_i[g];
  end
  assign irq_o = |hit;
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
  import uart_flag_pkg::*;
#(
  parameter int STAT_W = STAT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_tx_shift,
  input  logic              ev_tx_done,
  input  logic              ev_rx_ready,
  input  logic              ev_idle,
  input  logic              en_txe,
  input  logic              en_tc,
  input  logic              en_rx,
  input  logic              en_idle,
  input  logic              sr_rd,
  input  logic              sr_wr,
  input  logic [STAT_W-1:0] sr_wdata,
  input  logic              dr_rd,
  input  logic              dr_wr,
  output logic [STAT_W-1:0] status,
  output logic              rdr_load,
  output logic              irq
);
  localparam int LOW_W = B_OVR;

  logic txe_q, tc_q, rxne_q, idle_q, ovr_q, lock_q;
  logic dr_acc, ovr_set, idle_set;
  logic tc_wclr, rxne_wclr;
  logic [NSEQ-1:0] sq_set, sq_sel, sq_clr;
  logic unused_wbits;

  assign dr_acc   = dr_rd | dr_wr;
  assign rdr_load = ev_rx_ready & ~rxne_q;
  assign ovr_set  = ev_rx_ready & rxne_q;
  assign idle_set = ev_idle & ~lock_q;

  // only zeros written to bits 6 and 5 act
  assign tc_wclr   = sr_wr & ~sr_wdata[B_TC];
  assign rxne_wclr = sr_wr & ~sr_wdata[B_RXNE];
  assign unused_wbits = ^{sr_wdata[STAT_W-1:B_TC+1], sr_wdata[B_IDLE:0]};

  assign sq_set[SQ_TC]   = ev_tx_done;
  assign sq_set[SQ_IDLE] = idle_set;
  assign sq_set[SQ_OVR]  = ovr_set;
  assign sq_sel[SQ_TC]   = dr_wr;
  assign sq_sel[SQ_IDLE] = dr_rd;
  assign sq_sel[SQ_OVR]  = dr_rd;

  for (genvar g = 0; g < NSEQ; g++) begin : g_seq
    uart_flag_seqclr u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm_i    (sr_rd),
      .set_i    (sq_set[g]),
      .access_i (dr_acc),
      .sel_i    (sq_sel[g]),
      .clr_o    (sq_clr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txe_q  <= 1'b1;
      tc_q   <= 1'b1;
      rxne_q <= 1'b0;
      idle_q <= 1'b0;
      ovr_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      txe_q  <= ev_tx_shift | (txe_q & ~dr_wr);
      tc_q   <= ev_tx_done | (tc_q & ~(sq_clr[SQ_TC] | tc_wclr));
      rxne_q <= rdr_load | (rxne_q & ~(dr_rd | rxne_wclr));
      idle_q <= idle_set | (idle_q & ~sq_clr[SQ_IDLE]);
      ovr_q  <= ovr_set | (ovr_q & ~sq_clr[SQ_OVR]);
      lock_q <= idle_set | (lock_q & ~rdr_load);
    end
  end

  always_comb begin
    status          = '0;
    status[B_TXE]   = txe_q;
    status[B_TC]    = tc_q;
    status[B_RXNE]  = rxne_q;
    status[B_IDLE]  = idle_q;
    status[B_OVR]   = ovr_q;
  end

  uart_flag_irq #(.N(NIRQ)) u_irq (
    .src_i ({txe_q, tc_q, idle_q, rxne_q | ovr_q}),
    .en_i  ({en_txe, en_tc, en_idle, en_rx}),
    .irq_o (irq)
  );

  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status[LOW_W-1:0] == '0) else $error("low bits set"); // R1
  AST_TXE_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dr_wr && !ev_tx_shift |=> !status[B_TXE]) else $error("txe kept"); // R2
  AST_TC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_done |=> status[B_TC]) else $error("tc not set"); // R3
  AST_LOAD_SETS_RXNE: assert property (@(posedge clk) disable iff (!rst_n)
    rdr_load |=> status[B_RXNE]) else $error("rxne not set"); // R4
  AST_IDLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q && !rdr_load |=> !$rose(status[B_IDLE])) else $error("idle re-set"); // R6
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_ready && status[B_RXNE] |=> status[B_OVR]) else $error("ovr missed"); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_txe && !en_tc && !en_idle && !en_rx |-> !irq) else $error("stray irq"); // R10
  AST_WR_RO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr && !dr_acc && !ev_tx_shift && !ev_idle && !ev_rx_ready
      |=> $stable(status[B_TXE]) && !$rose(status[B_IDLE]) && !$rose(status[B_OVR]))
    else $error("ro bit changed"); // R11
endmodule

// File: tb/uart_flag_ctrl_tb.sv
module uart_flag_ctrl_tb;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_tx_shift = 0, ev_tx_done = 0, ev_rx_ready = 0, ev_idle = 0;
  logic en_txe = 0, en_tc = 0, en_rx = 0, en_idle = 0;
  logic sr_rd = 0, sr_wr = 0, dr_rd = 0, dr_wr = 0;
  logic [W-1:0] sr_wdata = '0;
  logic [W-1:0] status;
  logic rdr_load, irq;
  int n_chk = 0, n_err = 0;

  // model state
  logic m_txe, m_tc, m_rxne, m_idle, m_ovr, m_lock, a_tc, a_idle, a_ovr;

  always #10 clk = ~clk;

  uart_flag_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ev_tx_shift(ev_tx_shift), .ev_tx_done(ev_tx_done),
    .ev_rx_ready(ev_rx_ready), .ev_idle(ev_idle), .en_txe(en_txe), .en_tc(en_tc),
    .en_rx(en_rx), .en_idle(en_idle), .sr_rd(sr_rd), .sr_wr(sr_wr),
    .sr_wdata(sr_wdata), .dr_rd(dr_rd), .dr_wr(dr_wr), .status(status),
    .rdr_load(rdr_load), .irq(irq));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] m_status();
    return {m_txe, m_tc, m_rxne, m_idle, m_ovr, 3'b000};
  endfunction

  function automatic logic m_irq();
    return (m_txe & en_txe) | (m_tc & en_tc) | (m_idle & en_idle) | ((m_rxne | m_ovr) & en_rx);
  endfunction

  function automatic logic arm_next(input logic a, input logic set);
    if (set) return 1'b0;
    if (sr_rd) return 1'b1;
    if (dr_rd | dr_wr) return 1'b0;
    return a;
  endfunction

  task automatic model_reset();
    m_txe = 1; m_tc = 1; m_rxne = 0; m_idle = 0; m_ovr = 0; m_lock = 0;
    a_tc = 0; a_idle = 0; a_ovr = 0;
  endtask

  // next state from the requirements, using inputs of the finished cycle
  task automatic model_step();
    logic load, oset, iset;
    load = ev_rx_ready & ~m_rxne;
    oset = ev_rx_ready & m_rxne;
    iset = ev_idle & ~m_lock;
    m_txe  = ev_tx_shift | (m_txe & ~dr_wr);
    m_tc   = ev_tx_done | (m_tc & ~((a_tc & dr_wr) | (sr_wr & ~sr_wdata[6])));
    m_rxne = load | (m_rxne & ~(dr_rd | (sr_wr & ~sr_wdata[5])));
    m_idle = iset | (m_idle & ~(a_idle & dr_rd));
    m_ovr  = oset | (m_ovr & ~(a_ovr & dr_rd));
    m_lock = iset | (m_lock & ~load);
    a_tc   = arm_next(a_tc, ev_tx_done);
    a_idle = arm_next(a_idle, iset);
    a_ovr  = arm_next(a_ovr, oset);
  endtask

  task automatic clear_in();
    {ev_tx_shift, ev_tx_done, ev_rx_ready, ev_idle, sr_rd, sr_wr, dr_rd, dr_wr} = '0;
    sr_wdata = '0;
  endtask

  // inputs already driven after negedge: check comb outputs, clock, check regs
  task automatic cycle();
    #1;
    chk("R5 rdr_load", {7'd0, rdr_load}, {7'd0, ev_rx_ready & ~m_rxne});
    chk("R10 irq", {7'd0, irq}, {7'd0, m_irq()});
    @(posedge clk);
    #1 model_step();
    @(negedge clk);
    chk("R2 txe", {7'd0, status[7]}, {7'd0, m_txe});
    chk("R3 tc", {7'd0, status[6]}, {7'd0, m_tc});
    chk("R4 rxne", {7'd0, status[5]}, {7'd0, m_rxne});
    chk("R6 idle", {7'd0, status[4]}, {7'd0, m_idle});
    chk("R7 ovr", {7'd0, status[3]}, {7'd0, m_ovr});
    chk("R1 low", {5'd0, status[2:0]}, 8'd0);
    clear_in();
  endtask

  initial begin : watchdog
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset", status, 8'hC0);

    // R6: idle, two-step clear, lock until a new word loads
    ev_idle = 1; cycle();
    chk("R6 set", status & 8'h10, 8'h10);
    sr_rd = 1; cycle(); dr_rd = 1; cycle();
    chk("R6 cleared", status & 8'h10, 8'h00);
    ev_idle = 1; cycle();
    chk("R6 locked", status & 8'h10, 8'h00);
    ev_rx_ready = 1; cycle(); ev_idle = 1; cycle();
    chk("R6 rearmed", status & 8'h10, 8'h10);

    // R7: overrun keeps old word
    ev_rx_ready = 1; #1 chk("R7 no load", {7'd0, rdr_load}, 8'd0); cycle();
    chk("R7 ovr set", status & 8'h08, 8'h08);

    // R8: arm consumed by a read, later write does not clear tc
    sr_rd = 1; cycle(); dr_rd = 1; cycle(); dr_wr = 1; cycle();
    chk("R8 consumed", status & 8'h40, 8'h40);
    // R8: set after arming cancels clear
    sr_rd = 1; cycle(); ev_tx_done = 1; cycle(); dr_wr = 1; cycle();
    chk("R8 disarm", status & 8'h40, 8'h40);
    // R9: set and clear together
    sr_rd = 1; cycle(); dr_wr = 1; ev_tx_done = 1; ev_tx_shift = 1; cycle();
    chk("R9 tc", status & 8'h40, 8'h40);
    chk("R9 txe", status & 8'h80, 8'h80);
    // R11 and R3: status write of zeros
    ev_idle = 0; sr_wr = 1; sr_wdata = 8'h40; cycle();
    chk("R3 write1 keeps", status & 8'h40, 8'h40);
    sr_wr = 1; sr_wdata = 8'h00; cycle();
    chk("R11 ro bits", status & 8'h80, 8'h80);
    chk("R3 write0", status & 8'h40, 8'h00);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      ev_tx_shift = ($urandom % 8) == 0;
      ev_tx_done  = ($urandom % 8) == 0;
      ev_rx_ready = ($urandom % 6) == 0;
      ev_idle     = ($urandom % 6) == 0;
      sr_rd = ($urandom % 4) == 0;
      sr_wr = ($urandom % 10) == 0;
      sr_wdata = 8'($urandom);
      dr_rd = ($urandom % 5) == 0;
      dr_wr = ($urandom % 7) == 0;
      {en_txe, en_tc, en_rx, en_idle} = 4'($urandom);
      cycle();
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule